// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a station-management master for Ethernet PHYs. Software places a complete management frame, already encoded, into one 32-bit command register. The block then sends a run of preamble ones followed by the command word on the MDIO line, clocked by an MDC output whose rate comes from a divider register. For a read, the block releases the line for the turnaround and data bit times and captures the 16-bit reply from the PHY.

The end of every frame sets a sticky completion flag in an event register, and software clears that flag by writing a one to it. Software writes a command, polls the event register, and then reads the reply from the low half of the command register. The register bus is a plain single-cycle write strobe with a combinational read mux.

Top module: `mgmt_frame_ctrl`

## Requirements
- R1: After reset, mdc and mdio_oe are low, and the command, divider and event registers all read as zero.
- R2: A frame is 32 MDIO ones followed by command bits 31 down to 0, one bit per MDC period. While a frame runs, mdio_o changes only in the cycle in which MDC falls.
- R3: With a divider value D, MDC is high for D clock cycles and low for D clock cycles, so its period is 2*D cycles.
- R4: A command whose bits 29:28 equal 2'b10 is a read. For a read, mdio_oe is low for the last 18 bit times (2 turnaround and 16 data). For any other command, mdio_oe stays high for all 64 bit times.
- R5: For a read, mdio_i is sampled at each rising MDC edge of the 16 data bit times, MSB first. After the frame, bits 15:0 of the command register hold the reply. A read with no PHY driving the line returns 16'hFFFF.
- R6: At the falling MDC edge that ends the last bit, bit 23 of the event register becomes 1. It stays set until software clears it.
- R7: Writing the event register with bit 23 set clears the flag. Writing it with bit 23 clear leaves the flag unchanged.
- R8: While the divider register is zero, MDC stays low, a command write starts no frame, and no completion is flagged.
- R9: Writes to the command or divider register while a frame is running are ignored. The frame in progress, its MDC rate and the register contents are unaffected.
- R10: Register select 0 is the command/data register, 1 is the divider register (low 8 bits) and 2 is the event register. Every other bit reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| mdio_i | input | 1 | MDIO line as seen from the pad |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, high when the master drives |

## Verification
A bit counter that slips shows at the pins within one MDC period: the captured stream no longer matches the preamble and command, the frame has a number of MDC rises other than 64, or the output enable drops at the wrong bit time. A wrong half-period counter stretches the MDC high or low phase at the first edge. A bad read shift register or a bad latch into the command register appears only after the event flag sets, as a reply that differs from the PHY model's value or from 16'hFFFF. A command or divider write that gets through during a frame changes the bits that follow and the measured MDC period, and both of these are checked.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int CMD_W     = 32;
  localparam int DATA_BITS = 16;
  localparam int TA_BITS   = 2;

  typedef enum logic [1:0] {
    REG_CMD = 2'd0,
    REG_DIV = 2'd1,
    REG_EVT = 2'd2
  } reg_sel_e;

  // read opcode lives in bits 29:28 of the pre-encoded command word
  function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
    return c[29:28] == 2'b10;
  endfunction

  // bit sent at position idx of the frame (positions at or above CMD_W are preamble)
  function automatic logic frame_bit(input logic [CMD_W-1:0] c, input int idx);
    if (idx >= CMD_W) return 1'b1;
    return c[idx];
  endfunction

  // master lets go of the line during turnaround and data of a read
  function automatic logic line_released(input logic is_rd, input int idx);
    return is_rd && (idx < DATA_BITS + TA_BITS);
  endfunction

  function automatic logic in_data_window(input int idx);
    return idx < DATA_BITS;
  endfunction

endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             half_end;

  assign half_end  = run && (cnt_q == div - ONE);
  assign rise_tick = half_end && !mdc_q;
  assign fall_tick = half_end && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (half_end) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // R3: the half-period counter never passes the divider
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div));

endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CMD_W-1:0]     cmd,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdc,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic                 rd_valid,
  output logic [DATA_BITS-1:0] rd_data
);

  localparam int TOTAL = PRE_LEN + CMD_W;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic                 busy_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] rx_q;
  logic                 is_rd;
  logic                 last_bit;
  int                   idx_i;

  assign idx_i    = int'(idx_q);
  assign is_rd    = cmd_is_read(cmd);
  assign last_bit = busy_q && fall_tick && (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      rx_q   <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      idx_q  <= IDX_TOP;
      rx_q   <= '0;
    end else if (busy_q) begin
      if (rise_tick && is_rd && in_data_window(idx_i))
        rx_q <= {rx_q[DATA_BITS-2:0], mdio_i};
      if (fall_tick) begin
        if (idx_q == '0) busy_q <= 1'b0;
        else             idx_q  <= idx_q - IDX_ONE;
      end
    end
  end

  assign busy     = busy_q;
  assign mdio_o   = busy_q ? frame_bit(cmd, idx_i) : 1'b1;
  assign mdio_oe  = busy_q && !line_released(is_rd, idx_i);
  assign done     = last_bit;
  assign rd_valid = last_bit && is_rd;
  assign rd_data  = rx_q;

  // R2: inside a frame the driven bit moves only together with a falling MDC
  p_mdio_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $fell(mdc));

  // R2: the bit position advances only on a falling MDC edge
  p_idx_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(idx_q)) |-> $fell(mdc));

endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import mgmt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EVT_BIT = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [CMD_W-1:0]     reg_wdata,
  output logic [CMD_W-1:0]     reg_rdata,
  input  logic                 busy,
  input  logic                 done,
  input  logic                 rd_valid,
  input  logic [DATA_BITS-1:0] rd_data,
  output logic [CMD_W-1:0]     cmd,
  output logic [DIV_W-1:0]     div,
  output logic                 start
);

  logic [CMD_W-1:0] cmd_q;
  logic [DIV_W-1:0] div_q;
  logic             evt_q;
  logic             cmd_wr, div_wr, evt_clr;

  assign cmd_wr  = reg_wr && (reg_addr == REG_CMD) && !busy;
  assign div_wr  = reg_wr && (reg_addr == REG_DIV) && !busy;
  assign evt_clr = reg_wr && (reg_addr == REG_EVT) && reg_wdata[EVT_BIT];
  assign start   = cmd_wr && (div_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      div_q <= '0;
      evt_q <= 1'b0;
    end else begin
      if (cmd_wr)        cmd_q <= reg_wdata;
      else if (rd_valid) cmd_q[DATA_BITS-1:0] <= rd_data;
      if (div_wr)        div_q <= reg_wdata[DIV_W-1:0];
      if (done)          evt_q <= 1'b1;
      else if (evt_clr)  evt_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CMD: reg_rdata = cmd_q;
      REG_DIV: reg_rdata[DIV_W-1:0] = div_q;
      REG_EVT: reg_rdata[EVT_BIT] = evt_q;
      default: reg_rdata = '0;
    endcase
  end

  assign cmd = cmd_q;
  assign div = div_q;

  // R9: command word frozen for the whole frame
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q));

  // R9: divider frozen for the whole frame
  p_div_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));

  // R8: no frame can be in flight with a zero divider
  p_no_frame_div0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> !busy);

  // R6: flag rises only after the sequencer reports the end of a frame
  p_evt_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(done));

  // R6, R7: flag holds unless a clearing write arrives
  p_evt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !evt_clr) |=> evt_q);

endmodule

// File: rtl/mgmt_frame_ctrl.sv
module mgmt_frame_ctrl
  import mgmt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32,
  parameter int EVT_BIT = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);

  logic [CMD_W-1:0]     cmd;
  logic [DIV_W-1:0]     div;
  logic                 start, busy, done, rd_valid;
  logic [DATA_BITS-1:0] rd_data;
  logic                 rise_tick, fall_tick;

  mgmt_regs #(.DIV_W(DIV_W), .EVT_BIT(EVT_BIT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy     (busy),
    .done     (done),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .cmd      (cmd),
    .div      (div),
    .start    (start)
  );

  mgmt_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .div      (div),
    .mdc      (mdc),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  mgmt_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (cmd),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R4: the master lets go of the line only inside a read frame
  p_release_only_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |-> (cmd[29:28] == 2'b10));

endmodule

// File: tb/mgmt_frame_ctrl_tb.sv
module mgmt_frame_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PHY_ADDR = 5'd9;
  localparam logic [31:0] EVT_MASK = 32'h0080_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_bit = 1'b1;
  logic        mdio_i;

  int n_checks = 0;
  int n_err = 0;

  assign mdio_i = mdio_oe ? mdio_o : phy_bit;

  mgmt_frame_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor of the management pins
  logic [63:0] cap_bits, cap_oe;
  int          rcount = 0;
  time         prev_rise = 0, rise_gap = 0, high_len = 0;
  logic [31:0] cur_cmd = '0;

  function automatic logic [15:0] phy_value(input logic [4:0] r);
    return 16'hC3A5 ^ {11'd0, r} ^ ({11'd0, r} << 9);
  endfunction

  function automatic logic [31:0] mk_cmd(input logic rd, input logic [4:0] a,
                                         input logic [4:0] r, input logic [15:0] d);
    logic [31:0] c;
    c = rd ? 32'h6002_0000 : 32'h5002_0000;
    c = c | ({27'd0, a} << 23) | ({27'd0, r} << 18);
    if (!rd) c = c | {16'd0, d};
    return c;
  endfunction

  always @(posedge mdc) begin
    cap_bits = {cap_bits[62:0], mdio_o};
    cap_oe   = {cap_oe[62:0], mdio_oe};
    rise_gap = ($time - prev_rise) / CLK_PERIOD;
    prev_rise = $time;
    rcount++;
  end

  // PHY model: updates its output after MDC falls
  always @(negedge mdc) begin
    int nidx;
    high_len = ($time - prev_rise) / CLK_PERIOD;
    nidx = 63 - rcount;
    phy_bit = 1'b1;
    if (cur_cmd[29:28] == 2'b10 && cur_cmd[27:23] == PHY_ADDR && nidx >= 0 && nidx <= 16)
      phy_bit = (nidx == 16) ? 1'b0 : phy_value(cur_cmd[22:18])[nidx];
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_evt(input int limit, output logic seen);
    logic [31:0] v;
    seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      reg_read(2'd2, v);
      seen = (v == EVT_MASK);
    end
  endtask

  // issues one frame with divider dv and checks everything about it
  task automatic run_frame(input logic [31:0] c, input int dv);
    logic        rd, seen;
    logic [63:0] exp_bits, exp_oe;
    logic [31:0] v, exp_cmd;
    rd = (c[29:28] == 2'b10);
    cur_cmd = c; rcount = 0; phy_bit = 1'b1;
    reg_write(2'd0, c);
    wait_evt(64 * 2 * dv + 40, seen);
    check(seen, "R6 event set", {63'd0, seen}, 64'd1);
    exp_bits = {32'hFFFF_FFFF, c};
    exp_oe = rd ? ~64'h3FFFF : ~64'd0;
    check(rcount == 64, "R2 bit count", 64'(rcount), 64'd64);
    check((cap_bits & exp_oe) == (exp_bits & exp_oe), "R2 frame bits", cap_bits, exp_bits);
    check(cap_oe == exp_oe, "R4 output enable", cap_oe, exp_oe);
    check(rise_gap == 2 * dv, "R3 MDC period", 64'(rise_gap), 64'(2 * dv));
    check(high_len == dv, "R3 MDC high phase", 64'(high_len), 64'(dv));
    exp_cmd = c;
    if (rd) exp_cmd[15:0] = (c[27:23] == PHY_ADDR) ? phy_value(c[22:18]) : 16'hFFFF;
    reg_read(2'd0, v);
    check(v == exp_cmd, "R5 command/data readback", {32'd0, v}, {32'd0, exp_cmd});
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R6 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    reg_write(2'd2, EVT_MASK);
    reg_read(2'd2, v);
    check(v == 32'd0, "R7 event cleared", {32'd0, v}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        seen;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins after reset", {62'd0, mdc, mdio_oe}, 64'd0);
    reg_read(2'd0, v); check(v == 0, "R1 command reg", {32'd0, v}, 64'd0);
    reg_read(2'd1, v); check(v == 0, "R1 divider reg", {32'd0, v}, 64'd0);
    reg_read(2'd2, v); check(v == 0, "R1 event reg", {32'd0, v}, 64'd0);

    // R8: zero divider starts nothing
    rcount = 0;
    reg_write(2'd0, mk_cmd(1'b1, PHY_ADDR, 5'd2, 16'd0));
    repeat (100) @(negedge clk);
    check(rcount == 0 && mdio_oe == 1'b0, "R8 no MDC with zero divider", 64'(rcount), 64'd0);
    reg_read(2'd2, v); check(v == 0, "R8 no event with zero divider", {32'd0, v}, 64'd0);

    // R10: divider register readback
    reg_write(2'd1, 32'hFFFF_FF04);
    reg_read(2'd1, v); check(v == 32'd4, "R10 divider readback", {32'd0, v}, 64'd4);

    // directed: reads with and without a PHY, one write
    run_frame(mk_cmd(1'b1, PHY_ADDR, 5'd1, 16'd0), 4);
    run_frame(mk_cmd(1'b1, 5'd30, 5'd3, 16'd0), 4);   // R5: no PHY gives FFFF
    run_frame(mk_cmd(1'b0, 5'd0, 5'd31, 16'hA55A), 4);

    // R9: writes during a frame are ignored
    cur_cmd = mk_cmd(1'b0, 5'd7, 5'd4, 16'h1234); rcount = 0;
    reg_write(2'd0, cur_cmd);
    repeat (150) @(negedge clk);
    reg_write(2'd0, 32'h6002_FFFF);
    reg_write(2'd1, 32'd2);
    wait_evt(64 * 8 + 40, seen);
    check(seen, "R9 frame completes", {63'd0, seen}, 64'd1);
    check(cap_bits == {32'hFFFF_FFFF, cur_cmd}, "R9 frame unchanged", cap_bits, {32'hFFFF_FFFF, cur_cmd});
    check(rise_gap == 8, "R9 MDC rate unchanged", 64'(rise_gap), 64'd8);
    reg_read(2'd0, v); check(v == cur_cmd, "R9 command reg unchanged", {32'd0, v}, {32'd0, cur_cmd});
    reg_read(2'd1, v); check(v == 32'd4, "R9 divider unchanged", {32'd0, v}, 64'd4);

    // R7: writing zero to the flag keeps it, R6 sticky
    repeat (20) @(negedge clk);
    reg_write(2'd2, ~EVT_MASK);
    reg_read(2'd2, v); check(v == EVT_MASK, "R7 zero write keeps flag", {32'd0, v}, {32'd0, EVT_MASK});
    reg_write(2'd2, EVT_MASK);
    reg_read(2'd2, v); check(v == 0, "R7 one write clears flag", {32'd0, v}, 64'd0);

    // random frames
    for (int k = 0; k < 16; k++) begin
      int          dv;
      logic        rd;
      logic [4:0]  a, r;
      logic [15:0] d;
      dv = 2 * (int'($urandom % 4) + 1);
      rd = $urandom % 2;
      a  = ($urandom % 2) ? PHY_ADDR : 5'($urandom);
      r  = 5'($urandom);
      d  = 16'($urandom);
      reg_write(2'd1, 32'(dv));
      run_frame(mk_cmd(rd, a, r, d), dv);
    end

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule